// File: doc/BRIEF.md
# Sensor Open/Short Fault Annunciator

This block turns the slow bias-voltage readings of a sensor channel into a health verdict and a status lamp. Each accepted reading from the secondary converter is compared with a programmable upper and lower 12-bit limit. A reading above the upper limit is taken as a broken (open) sensor connection. A reading below the lower limit is taken as a shorted one. Anything between the limits is healthy. Either limit can be switched off with a reserved code. The verdict drives a two-colour lamp. The lamp is green when healthy, steady red when open and blinking red when shorted. It stays dark when the bias current is switched off.

A mode register picks the lamp source. The lamp can follow the verdict, or it can be forced to off, red, green or orange (both colours lit). Orange is only reachable through the forced mode.

The block also thins out the secondary data that is passed downstream. It counts main-converter sample strobes. Once every N strobes it grants one forwarding credit. The next accepted secondary reading is then passed on with a one-cycle strobe. An N of zero stops forwarding, but lamp classification keeps running.

Top module: `sensor_fault_annunciator`

## Requirements
- R1: While reset is held, both lamp outputs and the forward strobe are low.
- R2: In follow mode (alarmMode 0x3) with bias on, a reading strictly above threshHi lights red steadily with green off. When a reading is both above threshHi and below threshLo, open wins.
- R3: In follow mode with bias on, a reading strictly below threshLo gives a blinking red with green off. Red holds each level for FLASH_DIV cycles, so the period is 2*FLASH_DIV cycles.
- R4: A reading with threshLo <= reading <= threshHi is healthy and gives green only. A reading equal to either limit counts as healthy.
- R5: threshHi = 0xFFF disables the open test, and threshLo = 0x000 disables the short test.
- R6: In follow mode with biasOn low, both lamp outputs are low, whatever the verdict.
- R7: The alarmMode codes are: 0x0 gives off; 0x4 gives red only; 0x8 gives green only; 0xC gives red and green together. These forced codes ignore the verdict and biasOn. Any code not listed gives off.
- R8: In follow mode, red and green are never high at the same time.
- R9: While secEnable is low, secondary readings are ignored and the last verdict is held.
- R10: With decimN = N > 0, the N-th mainStrobe since the last grant (or since N became non-zero) grants one credit. The next accepted reading with the credit set raises fwdStrobe for one cycle, and in that cycle fwdReading equals that reading. Without a credit, no forward happens.
- R11: With decimN = 0, fwdStrobe stays low, and lamp classification still follows new readings.
- R12: A reading presented before clock edge k sets the verdict at edge k. The lamp shows that verdict from edge k+1. A forwarded reading raises fwdStrobe from edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| mainStrobe | input | 1 | One pulse per main-converter sample |
| secValid | input | 1 | Secondary reading present this cycle |
| secReading | input | READ_W | Secondary bias-voltage reading |
| secEnable | input | 1 | Secondary converter enabled; low holds the verdict |
| biasOn | input | 1 | Bias current applied to the sensor |
| threshHi | input | READ_W | Open-sensor limit, all ones disables |
| threshLo | input | READ_W | Short-sensor limit, zero disables |
| alarmMode | input | 4 | Lamp source select |
| decimN | input | CNT_W | Main samples per forwarded reading, zero stops forwarding |
| ledRed | output | 1 | Red lamp drive |
| ledGreen | output | 1 | Green lamp drive |
| fwdStrobe | output | 1 | One-cycle pulse with a forwarded reading |
| fwdReading | output | READ_W | Last forwarded reading |

## Verification
The comparator is driven with readings in the middle of the band, one code past each limit and exactly on each limit. This separates strict from inclusive comparisons and shows which test wins when the limits cross. The short case is sampled over a whole blink period to tell blinking red from steady red or from a lit green. The same readings are repeated with each limit set to its disabling code, with bias off and with the secondary converter disabled, to show that each gate masks the right test. The forwarding path is driven with strobe counts one short of N, exactly N and with N at zero. Readings are presented both with and without a granted credit.

// File: rtl/annun_pkg.sv
package annun_pkg;

  typedef enum logic [1:0] {
    CLS_OK    = 2'd0,
    CLS_OPEN  = 2'd1,
    CLS_SHORT = 2'd2
  } sensClassT;

  localparam logic [3:0] MODE_OFF    = 4'h0;
  localparam logic [3:0] MODE_FOLLOW = 4'h3;
  localparam logic [3:0] MODE_RED    = 4'h4;
  localparam logic [3:0] MODE_GREEN  = 4'h8;
  localparam logic [3:0] MODE_ORANGE = 4'hC;

  typedef struct packed {
    logic acceptReading;
    logic forwardReading;
    logic flashToggle;
  } ctrlStrobesT;

endpackage

// File: rtl/annun_ctrl.sv
module annun_ctrl
  import annun_pkg::*;
#(
  parameter int CNT_W     = 15,
  parameter int FLASH_DIV = 25_000_000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             mainStrobe,
  input  logic             secValid,
  input  logic             secEnable,
  input  logic [CNT_W-1:0] decimN,
  output ctrlStrobesT      strobes
);

  localparam int FLASH_W = (FLASH_DIV > 2) ? $clog2(FLASH_DIV) : 1;
  localparam logic [FLASH_W-1:0] FLASH_LAST = FLASH_W'(FLASH_DIV - 1);

  logic [CNT_W-1:0]   mainCnt;
  logic               credit;
  logic [FLASH_W-1:0] flashCnt;
  logic               nIsZero;
  logic               hitN;
  logic               accept;
  logic               forward;
  logic               flashTick;

  assign nIsZero   = (decimN == '0);
  assign accept    = secValid && secEnable;
  assign hitN      = mainStrobe && !nIsZero &&
                     (({1'b0, mainCnt} + 1'b1) >= {1'b0, decimN});
  assign forward   = accept && credit && !nIsZero;
  assign flashTick = (flashCnt == FLASH_LAST);

  // decimation counter and forwarding credit
  always_ff @(posedge clk) begin
    if (!rstN || nIsZero) begin
      mainCnt <= '0;
      credit  <= 1'b0;
    end else begin
      if (mainStrobe) mainCnt <= hitN ? '0 : mainCnt + 1'b1;
      if (hitN)         credit <= 1'b1;
      else if (forward) credit <= 1'b0;
    end
  end

  // free-running blink prescaler
  always_ff @(posedge clk) begin
    if (!rstN)          flashCnt <= '0;
    else if (flashTick) flashCnt <= '0;
    else                flashCnt <= flashCnt + 1'b1;
  end

  always_comb begin
    strobes.acceptReading  = accept;
    strobes.forwardReading = forward;
    strobes.flashToggle    = flashTick;
  end

endmodule

// File: rtl/annun_datapath.sv
module annun_datapath
  import annun_pkg::*;
#(
  parameter int READ_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobesT       strobes,
  input  logic [READ_W-1:0] secReading,
  input  logic [READ_W-1:0] threshHi,
  input  logic [READ_W-1:0] threshLo,
  input  logic [3:0]        alarmMode,
  input  logic              biasOn,
  output logic              ledRed,
  output logic              ledGreen,
  output logic              fwdStrobe,
  output logic [READ_W-1:0] fwdReading
);

  localparam logic [READ_W-1:0] HI_OFF = '1;
  localparam logic [READ_W-1:0] LO_OFF = '0;

  sensClassT sensClass;
  sensClassT classNext;
  logic      flashPhase;
  logic      redNext;
  logic      greenNext;

  always_comb begin
    if (threshHi != HI_OFF && secReading > threshHi)      classNext = CLS_OPEN;
    else if (threshLo != LO_OFF && secReading < threshLo) classNext = CLS_SHORT;
    else                                                  classNext = CLS_OK;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                      sensClass <= CLS_OK;
    else if (strobes.acceptReading) sensClass <= classNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                    flashPhase <= 1'b0;
    else if (strobes.flashToggle) flashPhase <= ~flashPhase;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fwdStrobe  <= 1'b0;
      fwdReading <= '0;
    end else begin
      fwdStrobe <= strobes.forwardReading;
      if (strobes.forwardReading) fwdReading <= secReading;
    end
  end

  always_comb begin
    redNext   = 1'b0;
    greenNext = 1'b0;
    case (alarmMode)
      MODE_FOLLOW: begin
        if (biasOn) begin
          case (sensClass)
            CLS_OK:    greenNext = 1'b1;
            CLS_OPEN:  redNext   = 1'b1;
            CLS_SHORT: redNext   = flashPhase;
            default:   ;
          endcase
        end
      end
      MODE_RED:    redNext = 1'b1;
      MODE_GREEN:  greenNext = 1'b1;
      MODE_ORANGE: begin
        redNext   = 1'b1;
        greenNext = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ledRed   <= 1'b0;
      ledGreen <= 1'b0;
    end else begin
      ledRed   <= redNext;
      ledGreen <= greenNext;
    end
  end

endmodule

// File: rtl/sensor_fault_annunciator.sv
module sensor_fault_annunciator
  import annun_pkg::*;
#(
  parameter int READ_W    = 12,
  parameter int CNT_W     = 15,
  parameter int FLASH_DIV = 25_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mainStrobe,
  input  logic              secValid,
  input  logic [READ_W-1:0] secReading,
  input  logic              secEnable,
  input  logic              biasOn,
  input  logic [READ_W-1:0] threshHi,
  input  logic [READ_W-1:0] threshLo,
  input  logic [3:0]        alarmMode,
  input  logic [CNT_W-1:0]  decimN,
  output logic              ledRed,
  output logic              ledGreen,
  output logic              fwdStrobe,
  output logic [READ_W-1:0] fwdReading
);

  ctrlStrobesT strobes;

  annun_ctrl #(.CNT_W(CNT_W), .FLASH_DIV(FLASH_DIV)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .mainStrobe (mainStrobe),
    .secValid   (secValid),
    .secEnable  (secEnable),
    .decimN     (decimN),
    .strobes    (strobes)
  );

  annun_datapath #(.READ_W(READ_W)) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .secReading (secReading),
    .threshHi   (threshHi),
    .threshLo   (threshLo),
    .alarmMode  (alarmMode),
    .biasOn     (biasOn),
    .ledRed     (ledRed),
    .ledGreen   (ledGreen),
    .fwdStrobe  (fwdStrobe),
    .fwdReading (fwdReading)
  );

endmodule

// File: rtl/annun_checker.sv
module annun_checker
  import annun_pkg::*;
#(
  parameter int READ_W = 12,
  parameter int CNT_W  = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              secValid,
  input logic [READ_W-1:0] secReading,
  input logic              secEnable,
  input logic              biasOn,
  input logic [3:0]        alarmMode,
  input logic [CNT_W-1:0]  decimN,
  input logic              ledRed,
  input logic              ledGreen,
  input logic              fwdStrobe,
  input logic [READ_W-1:0] fwdReading
);

  p_follow_no_orange_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(alarmMode) == MODE_FOLLOW) |-> !(ledRed && ledGreen));

  p_bias_dark_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(alarmMode) == MODE_FOLLOW && !$past(biasOn)) |-> (!ledRed && !ledGreen));

  p_forced_green_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(alarmMode) == MODE_GREEN) |-> (ledGreen && !ledRed));

  p_fwd_from_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    fwdStrobe |-> ($past(secValid && secEnable) && fwdReading == $past(secReading)));

  p_zero_n_silent_r11: assert property (@(posedge clk) disable iff (!rstN)
    ($past(decimN) == '0) |-> !fwdStrobe);

endmodule

bind sensor_fault_annunciator annun_checker #(.READ_W(READ_W), .CNT_W(CNT_W)) i_checker (
  .clk        (clk),
  .rstN       (rstN),
  .secValid   (secValid),
  .secReading (secReading),
  .secEnable  (secEnable),
  .biasOn     (biasOn),
  .alarmMode  (alarmMode),
  .decimN     (decimN),
  .ledRed     (ledRed),
  .ledGreen   (ledGreen),
  .fwdStrobe  (fwdStrobe),
  .fwdReading (fwdReading)
);

// File: tb/test_sensor_fault_annunciator.sv
module test_sensor_fault_annunciator;

  localparam int CLK_PERIOD = 10;
  localparam int READ_W     = 12;
  localparam int CNT_W      = 15;
  localparam int FLASH_DIV  = 4;

  logic              clk = 1'b0;
  logic              rstN;
  logic              mainStrobe;
  logic              secValid;
  logic [READ_W-1:0] secReading;
  logic              secEnable;
  logic              biasOn;
  logic [READ_W-1:0] threshHi;
  logic [READ_W-1:0] threshLo;
  logic [3:0]        alarmMode;
  logic [CNT_W-1:0]  decimN;
  logic              ledRed;
  logic              ledGreen;
  logic              fwdStrobe;
  logic [READ_W-1:0] fwdReading;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    string             tag;
    logic              red;
    logic              green;
    logic              fwd;
    bit                chkData;
    logic [READ_W-1:0] data;
  } expT;

  expT expQ[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  sensor_fault_annunciator #(
    .READ_W(READ_W), .CNT_W(CNT_W), .FLASH_DIV(FLASH_DIV)
  ) i_sensor_fault_annunciator (
    .clk(clk), .rstN(rstN), .mainStrobe(mainStrobe), .secValid(secValid),
    .secReading(secReading), .secEnable(secEnable), .biasOn(biasOn),
    .threshHi(threshHi), .threshLo(threshLo), .alarmMode(alarmMode),
    .decimN(decimN), .ledRed(ledRed), .ledGreen(ledGreen),
    .fwdStrobe(fwdStrobe), .fwdReading(fwdReading)
  );

  // monitor: compares queued expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (expQ.size() > 0) begin
        expT e;
        e = expQ.pop_front();
        checks++;
        if (ledRed !== e.red || ledGreen !== e.green || fwdStrobe !== e.fwd ||
            (e.chkData && fwdReading !== e.data)) begin
          errors++;
          $display("FAIL %s: red/green/fwd/data actual %b/%b/%b/%h expected %b/%b/%b/%h",
                   e.tag, ledRed, ledGreen, fwdStrobe, fwdReading,
                   e.red, e.green, e.fwd, e.data);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pushExp(input string tag, input logic r, input logic g, input logic f,
                         input bit cd = 1'b0, input logic [READ_W-1:0] d = '0);
    expT e;
    e.tag = tag; e.red = r; e.green = g; e.fwd = f; e.chkData = cd; e.data = d;
    expQ.push_back(e);
  endtask

  task automatic checkVal(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // present one reading; returns at the falling edge after it was sampled
  task automatic present(input logic [READ_W-1:0] r);
    secValid   = 1'b1;
    secReading = r;
    tick(1);
    secValid   = 1'b0;
  endtask

  task automatic strobeMain(input int n);
    for (int i = 0; i < n; i++) begin
      mainStrobe = 1'b1;
      tick(1);
      mainStrobe = 1'b0;
      tick(1);
    end
  endtask

  initial begin
    int redCnt;
    int greenCnt;
    rstN = 1'b0; mainStrobe = 1'b0; secValid = 1'b0; secReading = '0;
    secEnable = 1'b1; biasOn = 1'b1; threshHi = 12'hFA0; threshLo = 12'h0C0;
    alarmMode = 4'h3; decimN = '0;
    tick(3);
    pushExp("R1 reset", 1'b0, 1'b0, 1'b0);
    tick(1);
    rstN = 1'b1;
    tick(2);

    present(12'h800); tick(1);
    pushExp("R4 mid band green, R12 latency", 1'b0, 1'b1, 1'b0);

    present(12'hFA1);
    pushExp("R12 lamp not yet updated", 1'b0, 1'b1, 1'b0);
    tick(1);
    pushExp("R2 open red", 1'b1, 1'b0, 1'b0);
    tick(FLASH_DIV);
    pushExp("R2 open red steady", 1'b1, 1'b0, 1'b0);

    present(12'hFA0); tick(1);
    pushExp("R4 equal high limit is healthy", 1'b0, 1'b1, 1'b0);
    present(12'h0C0); tick(1);
    pushExp("R4 equal low limit is healthy", 1'b0, 1'b1, 1'b0);

    present(12'h0BF); tick(1);
    redCnt = 0; greenCnt = 0;
    for (int i = 0; i < 4 * FLASH_DIV; i++) begin
      tick(1);
      redCnt   += int'(ledRed);
      greenCnt += int'(ledGreen);
    end
    checkVal("R3 short red blinks half the time", redCnt, 2 * FLASH_DIV);
    checkVal("R3 R8 short keeps green off", greenCnt, 0);

    biasOn = 1'b0; tick(2);
    pushExp("R6 bias off dark", 1'b0, 1'b0, 1'b0);
    biasOn = 1'b1;

    threshHi = 12'hFFF;
    present(12'hFFE); tick(1);
    pushExp("R5 open test disabled", 1'b0, 1'b1, 1'b0);
    threshLo = 12'h000;
    present(12'h000); tick(1);
    pushExp("R5 short test disabled", 1'b0, 1'b1, 1'b0);

    threshHi = 12'h100; threshLo = 12'h200;
    present(12'h180); tick(1);
    pushExp("R2 open wins over short", 1'b1, 1'b0, 1'b0);
    tick(FLASH_DIV);
    pushExp("R2 open wins, steady", 1'b1, 1'b0, 1'b0);
    threshHi = 12'hFA0; threshLo = 12'h0C0;

    present(12'h800); tick(1);
    secEnable = 1'b0;
    present(12'hFF0); tick(2);
    pushExp("R9 disabled reading ignored", 1'b0, 1'b1, 1'b0);
    secEnable = 1'b1;

    alarmMode = 4'h4; tick(2);
    pushExp("R7 forced red", 1'b1, 1'b0, 1'b0);
    alarmMode = 4'h8; biasOn = 1'b0; tick(2);
    pushExp("R7 forced green ignores bias", 1'b0, 1'b1, 1'b0);
    biasOn = 1'b1;
    alarmMode = 4'hC; tick(2);
    pushExp("R7 forced orange", 1'b1, 1'b1, 1'b0);
    alarmMode = 4'h0; tick(2);
    pushExp("R7 off code", 1'b0, 1'b0, 1'b0);
    alarmMode = 4'h5; tick(2);
    pushExp("R7 unlisted code off", 1'b0, 1'b0, 1'b0);
    alarmMode = 4'h3; tick(2);

    decimN = 15'd3;
    strobeMain(3);
    present(12'h123);
    pushExp("R10 forward after N strobes", 1'b0, 1'b1, 1'b1, 1'b1, 12'h123);
    tick(1);
    pushExp("R10 forward strobe one cycle", 1'b0, 1'b1, 1'b0);
    present(12'h456);
    pushExp("R10 no credit no forward", 1'b0, 1'b1, 1'b0);
    strobeMain(2);
    present(12'h457);
    pushExp("R10 N-1 strobes no forward", 1'b0, 1'b1, 1'b0);
    strobeMain(1);
    present(12'h789);
    pushExp("R10 N-th strobe grants", 1'b0, 1'b1, 1'b1, 1'b1, 12'h789);
    tick(1);

    decimN = '0;
    strobeMain(5);
    present(12'hFA1);
    pushExp("R11 zero N no forward", 1'b0, 1'b1, 1'b0);
    tick(1);
    pushExp("R11 classification still runs", 1'b1, 1'b0, 1'b0);
    tick(2);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule